// File: doc/BRIEF.md
# Armed Interrupt Request Controller

This block collects interrupt events from a set of peripheral sources and turns them into a single request line and a vector address for a small processor core. Every source owns a latched event flag, set by hardware, and an enable-for-interrupt bit, loaded by software. A single global mask bit sits in front of every armed request. When the core is at an instruction boundary and a request is present, the block accepts it. It then pulses an acknowledge, presents the vector of the winning source, and raises the global mask so that a running handler is not interrupted again.

Flags are never cleared by acceptance. The handler clears them through a write-one-to-clear port. A flag that is left set asks again once the return handshake has put the mask back to its saved value. When the mask is raised, pending flags are held rather than dropped, and they are served after the mask falls. Among several armed pending sources, the one with the highest vector address wins. Source i uses vector `VEC_TOP - 2*i`, so source 0 has the highest priority.

Top module: `irq_arm_ctrl`

## Requirements
- R1: A `src_evt_i[i]` pulse sets flag i, seen on `flag_o[i]` one cycle later; the flag stays set until cleared.
- R2: A cycle with `clr_we_i=1` clears each flag whose bit in `clr_bits_i` is 1; flags whose bit is 0 keep their value.
- R3: If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R4: `irq_o` is 1 exactly when some source has both its flag and its arm bit set and `mask_o` is 0.
- R5: While `mask_o` is 1, pending flags stay latched and no acknowledge occurs; once the mask is written to 0, the request is accepted.
- R6: A request is accepted only in a cycle with `instr_done_i=1` and `irq_o=1`; `ack_o` is 1 in the following cycle for exactly one cycle.
- R7: In the cycle `ack_o` is 1, `mask_o` is already 1.
- R8: On acceptance, `vec_o` becomes `VEC_TOP - 2*i` for the lowest-index armed pending source i. It stays unchanged until the next acceptance.
- R9: Acceptance leaves every flag unchanged, so an uncleared flag raises `irq_o` again after return.
- R10: A `ret_i` pulse restores `mask_o` to the value it held just before the last acceptance; `ret_i` takes precedence over a mask write in the same cycle.
- R11: After reset, all flags and arm bits are 0, `mask_o` is 1, `ack_o` is 0 and `vec_o` equals `RESET_VEC` (0xFFFE).
- R12: `arm_we_i` loads `arm_bits_i` into the arm register; `mask_we_i` loads `mask_wdata_i` into the mask when no acceptance or return occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt_i | input | N_SRC | Hardware event pulses, one per source |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_bits_i | input | N_SRC | Write-one-to-clear flag mask |
| arm_we_i | input | 1 | Arm register write strobe |
| arm_bits_i | input | N_SRC | New arm bits |
| mask_we_i | input | 1 | Global mask write strobe |
| mask_wdata_i | input | 1 | New global mask value |
| instr_done_i | input | 1 | Core is at an instruction boundary |
| ret_i | input | 1 | Handler return handshake |
| irq_o | output | 1 | Request pending toward the core |
| ack_o | output | 1 | One-cycle acceptance pulse |
| vec_o | output | 16 | Vector address of the accepted source |
| flag_o | output | N_SRC | Current flag register |
| arm_o | output | N_SRC | Current arm register |
| mask_o | output | 1 | Current global mask |

## Verification
On every cycle, the assertions check the following. The acknowledge is one cycle long and follows a boundary cycle with a request. The mask is up whenever the acknowledge is. The vector holds after an acknowledge. A raised mask silences the request. An event is never lost to a clear, and at most one source is granted. The bench sweeps flag patterns against several arm patterns. It covers what only sequences can show: which source wins and which vector it gets, that flags survive acceptance and ask again after return, that the mask is restored by return, and that a postponed request is served once the mask falls.

// File: rtl/irq_arm_pkg.sv
package irq_arm_pkg;

    localparam int VEC_W = 16;

    typedef logic [VEC_W-1:0] vec_t;

    // Vector slot of a source: two bytes per slot, descending from the top.
    function automatic vec_t src_vector(input vec_t top, input int unsigned idx);
        return top - vec_t'(2 * idx);
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt_i,
    input  logic             clr_we_i,
    input  logic [N_SRC-1:0] clr_bits_i,
    input  logic             arm_we_i,
    input  logic [N_SRC-1:0] arm_bits_i,
    output logic [N_SRC-1:0] flag_o,
    output logic [N_SRC-1:0] arm_o
);

    typedef struct packed {
        logic [N_SRC-1:0] flag;
        logic [N_SRC-1:0] arm;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (clr_we_i) begin
            bank_d.flag = bank_q.flag & ~clr_bits_i;
        end
        // A new event overrides a clear of the same bit.
        bank_d.flag = bank_d.flag | src_evt_i;
        if (arm_we_i) begin
            bank_d.arm = arm_bits_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign flag_o = bank_q.flag;
    assign arm_o  = bank_q.arm;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_arm_pkg::*;
#(
    parameter int   N_SRC   = 8,
    parameter vec_t VEC_TOP = 16'hFFEE
) (
    input  logic [N_SRC-1:0] pend_i,
    output logic             any_o,
    output logic [N_SRC-1:0] grant_o,
    output vec_t             vec_o
);

    vec_t vec_tab [N_SRC];

    for (genvar i = 0; i < N_SRC; i++) begin : g_slot
        assign vec_tab[i] = src_vector(VEC_TOP, i);
        if (i == 0) begin : g_top
            assign grant_o[i] = pend_i[i];
        end else begin : g_rest
            assign grant_o[i] = pend_i[i] & ~(|pend_i[i-1:0]);
        end
    end

    assign any_o = |pend_i;

    always_comb begin
        vec_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant_o[i]) begin
                vec_o = vec_o | vec_tab[i];
            end
        end
    end

endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic ret_i,
    input  logic mask_we_i,
    input  logic mask_wdata_i,
    output logic mask_o
);

    typedef struct packed {
        logic mask;
        logic saved;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept_i) begin
            st_d.saved = st_q.mask;
            st_d.mask  = 1'b1;
        end else if (ret_i) begin
            st_d.mask  = st_q.saved;
        end else if (mask_we_i) begin
            st_d.mask  = mask_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mask: 1'b1, saved: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;

endmodule

// File: rtl/irq_arm_ctrl.sv
module irq_arm_ctrl
    import irq_arm_pkg::*;
#(
    parameter int   N_SRC     = 8,
    parameter vec_t VEC_TOP   = 16'hFFEE,
    parameter vec_t RESET_VEC = 16'hFFFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt_i,
    input  logic             clr_we_i,
    input  logic [N_SRC-1:0] clr_bits_i,
    input  logic             arm_we_i,
    input  logic [N_SRC-1:0] arm_bits_i,
    input  logic             mask_we_i,
    input  logic             mask_wdata_i,
    input  logic             instr_done_i,
    input  logic             ret_i,
    output logic             irq_o,
    output logic             ack_o,
    output logic [15:0]      vec_o,
    output logic [N_SRC-1:0] flag_o,
    output logic [N_SRC-1:0] arm_o,
    output logic             mask_o
);

    typedef struct packed {
        logic ack;
        vec_t vec;
    } out_st_t;

    logic [N_SRC-1:0] flag_w, arm_w, pend, grant;
    logic             any_pend, mask_w, accept;
    vec_t             win_vec;
    out_st_t          out_d, out_q;

    irq_flag_bank #(.N_SRC(N_SRC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_evt_i  (src_evt_i),
        .clr_we_i   (clr_we_i),
        .clr_bits_i (clr_bits_i),
        .arm_we_i   (arm_we_i),
        .arm_bits_i (arm_bits_i),
        .flag_o     (flag_w),
        .arm_o      (arm_w)
    );

    assign pend = flag_w & arm_w;

    irq_prio_enc #(.N_SRC(N_SRC), .VEC_TOP(VEC_TOP)) u_prio (
        .pend_i  (pend),
        .any_o   (any_pend),
        .grant_o (grant),
        .vec_o   (win_vec)
    );

    assign irq_o  = any_pend & ~mask_w;
    assign accept = irq_o & instr_done_i;

    irq_mask_ctl u_mask (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .ret_i        (ret_i),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .mask_o       (mask_w)
    );

    always_comb begin
        out_d     = out_q;
        out_d.ack = accept;
        if (accept) begin
            out_d.vec = win_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{ack: 1'b0, vec: RESET_VEC};
        end else begin
            out_q <= out_d;
        end
    end

    assign ack_o  = out_q.ack;
    assign vec_o  = out_q.vec;
    assign flag_o = flag_w;
    assign arm_o  = arm_w;
    assign mask_o = mask_w;

endmodule

// File: rtl/irq_arm_checker.sv
module irq_arm_checker #(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_evt_i,
    input logic             instr_done_i,
    input logic             irq_o,
    input logic             ack_o,
    input logic [15:0]      vec_o,
    input logic [N_SRC-1:0] flag_o,
    input logic             mask_o,
    input logic [N_SRC-1:0] grant
);

    a_r6_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    a_r6_ack_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(instr_done_i) && $past(irq_o)));

    a_r7_mask_up_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> mask_o);

    a_r8_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> $stable(vec_o));

    a_r4_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        mask_o |-> !irq_o);

    a_r3_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt_i != '0) |=> ((flag_o & $past(src_evt_i)) == $past(src_evt_i)));

    a_r8_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

endmodule

bind irq_arm_ctrl irq_arm_checker #(.N_SRC(N_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_evt_i    (src_evt_i),
    .instr_done_i (instr_done_i),
    .irq_o        (irq_o),
    .ack_o        (ack_o),
    .vec_o        (vec_o),
    .flag_o       (flag_o),
    .mask_o       (mask_o),
    .grant        (grant)
);

// File: tb/tb_irq_arm_ctrl.sv
module tb_irq_arm_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_evt_i = '0;
    logic         clr_we_i = 1'b0;
    logic [N-1:0] clr_bits_i = '0;
    logic         arm_we_i = 1'b0;
    logic [N-1:0] arm_bits_i = '0;
    logic         mask_we_i = 1'b0;
    logic         mask_wdata_i = 1'b0;
    logic         instr_done_i = 1'b0;
    logic         ret_i = 1'b0;
    logic         irq_o, ack_o, mask_o;
    logic [15:0]  vec_o;
    logic [N-1:0] flag_o, arm_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_arm_ctrl #(.N_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt_i),
        .clr_we_i(clr_we_i), .clr_bits_i(clr_bits_i),
        .arm_we_i(arm_we_i), .arm_bits_i(arm_bits_i),
        .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
        .instr_done_i(instr_done_i), .ret_i(ret_i),
        .irq_o(irq_o), .ack_o(ack_o), .vec_o(vec_o),
        .flag_o(flag_o), .arm_o(arm_o), .mask_o(mask_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_vec(input logic [N-1:0] pend);
        for (int i = 0; i < N; i++) begin
            if (pend[i]) return 16'hFFEE - 16'(2 * i);
        end
        return 16'h0000;
    endfunction

    function automatic logic [N-1:0] lowest(input logic [N-1:0] pend);
        for (int i = 0; i < N; i++) begin
            if (pend[i]) return N'(1) << i;
        end
        return '0;
    endfunction

    task automatic clear_all();
        clr_we_i = 1'b1; clr_bits_i = '1; mask_we_i = 1'b1; mask_wdata_i = 1'b1;
        step();
        clr_we_i = 1'b0; clr_bits_i = '0; mask_we_i = 1'b0;
    endtask

    task automatic sweep_one(input logic [N-1:0] p, input logic [N-1:0] a);
        logic [N-1:0] pa, win;
        logic         acc;
        logic [15:0]  ev;
        pa  = p & a;
        acc = |pa;
        win = lowest(pa);
        ev  = exp_vec(pa);
        clear_all();
        arm_we_i = 1'b1; arm_bits_i = a; src_evt_i = p;
        step();
        arm_we_i = 1'b0; src_evt_i = '0;
        check("R1 flag latch", 32'(flag_o), 32'(p));
        check("R12 arm load", 32'(arm_o), 32'(a));
        mask_we_i = 1'b1; mask_wdata_i = 1'b0;
        step();
        mask_we_i = 1'b0;
        check("R12 mask write", 32'(mask_o), 32'(0));
        check("R4 irq gate", 32'(irq_o), 32'(acc));
        instr_done_i = 1'b1;
        step();
        instr_done_i = 1'b0;
        check("R6 ack", 32'(ack_o), 32'(acc));
        check("R7 mask on ack", 32'(mask_o), 32'(acc));
        if (acc) check("R8 vector", 32'(vec_o), 32'(ev));
        step();
        check("R6 ack width", 32'(ack_o), 32'(0));
        check("R9 flags kept", 32'(flag_o), 32'(p));
        if (acc) begin
            check("R8 vector held", 32'(vec_o), 32'(ev));
            ret_i = 1'b1;
            step();
            ret_i = 1'b0;
            check("R10 mask restored", 32'(mask_o), 32'(0));
            check("R9 re-request", 32'(irq_o), 32'(1));
            clr_we_i = 1'b1; clr_bits_i = win;
            step();
            clr_we_i = 1'b0; clr_bits_i = '0;
            check("R2 partial clear", 32'(flag_o), 32'(p & ~win));
            check("R4 irq after clear", 32'(irq_o), 32'(|(pa & ~win)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        // R11 reset state
        check("R11 flags", 32'(flag_o), 32'(0));
        check("R11 arm", 32'(arm_o), 32'(0));
        check("R11 mask", 32'(mask_o), 32'(1));
        check("R11 ack", 32'(ack_o), 32'(0));
        check("R11 irq", 32'(irq_o), 32'(0));
        check("R11 vector", 32'(vec_o), 32'h0000FFFE);

        // R3: event and clear on the same bit
        src_evt_i = 8'h01; step(); src_evt_i = '0;
        src_evt_i = 8'h01; clr_we_i = 1'b1; clr_bits_i = 8'h03; step();
        src_evt_i = '0; clr_we_i = 1'b0; clr_bits_i = '0;
        check("R3 set wins", 32'(flag_o[0]), 32'(1));

        // R5: postponement while masked, then served
        clear_all();
        arm_we_i = 1'b1; arm_bits_i = '1; src_evt_i = 8'h08; step();
        arm_we_i = 1'b0; src_evt_i = '0;
        instr_done_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            check("R5 no ack while masked", 32'(ack_o), 32'(0));
            check("R5 no irq while masked", 32'(irq_o), 32'(0));
            check("R5 flag held", 32'(flag_o), 32'h08);
        end
        mask_we_i = 1'b1; mask_wdata_i = 1'b0; step(); mask_we_i = 1'b0;
        check("R5 irq after unmask", 32'(irq_o), 32'(1));
        step();
        instr_done_i = 1'b0;
        check("R5 served", 32'(ack_o), 32'(1));
        check("R5 vector", 32'(vec_o), 32'h0000FFE8);

        // R10: return beats a mask write in the same cycle
        ret_i = 1'b1; mask_we_i = 1'b1; mask_wdata_i = 1'b1; step();
        ret_i = 1'b0; mask_we_i = 1'b0;
        check("R10 return precedence", 32'(mask_o), 32'(0));

        // R6: no acceptance away from an instruction boundary
        for (int k = 0; k < 3; k++) begin
            step();
            check("R6 no boundary no ack", 32'(ack_o), 32'(0));
            check("R6 irq still up", 32'(irq_o), 32'(1));
        end

        // Sweep every flag pattern against several arm patterns
        for (int p = 0; p < 256; p++) begin
            sweep_one(8'(p), 8'hFF);
            sweep_one(8'(p), 8'h5A);
            sweep_one(8'(p), 8'hF0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule